// File: doc/BRIEF.md
# Byte Substitution Unit with Shared Field Inverter

This unit applies the AES byte substitution to a single byte, or its inverse, with one mode input choosing between the two. No lookup table is used. A single multi-cycle inverter over GF(2^8) serves both directions and computes the inverse with the extended Euclidean algorithm on binary polynomials. In the forward direction the byte goes through the inverter first and then through the forward affine map. In the reverse direction the inverse affine map is applied to the byte before it enters the inverter.

A caller places a byte on `din`, sets `decrypt` and pulses `start` while `busy` is low. The unit reduces a pair of polynomials by one step per cycle and spends one further cycle on the output affine stage. It then pulses `done` for exactly one cycle, and `dout` holds the result from that point on. A single round datapath can share one instance for both cipher directions, or key expansion can use it, when area matters more than throughput.

Top module: `byte_sub_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, `done` and `busy` are low and `dout` is 0x00.
- R2: With `decrypt` = 0, the result is A(inv(x)). inv is the multiplicative inverse modulo x^8+x^4+x^3+x+1 (0x11B). In A, output bit i is the XOR of input bits i, i+4, i+5, i+6 and i+7 (mod 8) and bit i of 0x63.
- R3: The inverter maps 0x00 to 0x00. Forward 0x00 therefore gives 0x63, and reverse 0x63 gives 0x00.
- R4: With `decrypt` = 1, the result is inv(B(y)). In B, output bit i is the XOR of input bits i+2, i+5 and i+7 (mod 8) and bit i of 0x05.
- R5: For every byte x, running the reverse direction on the forward result of x returns x.
- R6: Each accepted start produces exactly one `done` pulse, one cycle wide. `dout` changes only in the cycle in which `done` is high and then holds its value.
- R7: A `start` pulse that arrives while `busy` is high is ignored. It starts no second operation, and the running operation keeps its own byte and mode.
- R8: `busy` rises in the cycle after an accepted start. `done` is seen no more than 18 cycles after that start, because the inverter needs at most 16 iteration cycles.
- R9: Known forward values hold: 0x53 maps to 0xED and 0x00 maps to 0x63.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the unit is idle |
| decrypt | input | 1 | 0 selects the forward substitution, 1 selects the inverse |
| din | input | 8 | Byte to substitute, sampled with an accepted start |
| busy | output | 1 | High from acceptance until the done cycle |
| done | output | 1 | One-cycle pulse when the result is ready |
| dout | output | 8 | Result byte, held until the next completion |

## Verification
Every byte value goes through both directions and is compared with a reference. The reference finds the field inverse by searching for the partner whose product is one, and it builds the forward map as a sum of byte rotations. Because that construction is unlike the bit-mask form used in the design, a wrong tap or constant in either affine stage shows up. The reverse sweep also covers the bytes that reach the inverter as 0x00 and 0x01, which take the shortest path through the iteration. The forward-then-reverse round trip and the latency bound check each byte's iteration count. A start pulse during a running job, with a different byte and the other mode, shows whether the latched operands survive.

// File: rtl/sbsub_pkg.sv
package sbsub_pkg;
    localparam int BYTE_W  = 8;
    localparam int POLY_W  = BYTE_W + 1;
    localparam int DEG_W   = $clog2(POLY_W);
    localparam logic [POLY_W-1:0] FIELD_POLY = 9'h11B;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ITER,
        ST_AFF,
        ST_DONE
    } sbsub_state_e;

    typedef struct packed {
        sbsub_state_e        st;
        logic                mode;
        logic [POLY_W-1:0]   u;
        logic [POLY_W-1:0]   v;
        logic [POLY_W-1:0]   g1;
        logic [POLY_W-1:0]   g2;
        logic [BYTE_W-1:0]   inv;
        logic [BYTE_W-1:0]   res;
    } sbsub_regs_t;

    // index of the highest set bit; 0 for a zero polynomial
    function automatic logic [DEG_W-1:0] poly_deg(input logic [POLY_W-1:0] p);
        logic [DEG_W-1:0] d;
        d = '0;
        for (int i = 0; i < POLY_W; i++) begin
            if (p[i]) d = DEG_W'(i);
        end
        return d;
    endfunction
endpackage

// File: rtl/gf_affine.sv
module gf_affine #(
    parameter int               W    = 8,
    parameter logic [W-1:0]     TAPS = 8'hF1,
    parameter logic [W-1:0]     CONST = 8'h63
) (
    input  logic [W-1:0] a_i,
    output logic [W-1:0] y_o
);
    // bit i uses the tap pattern rotated left by i
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [2*W-1:0] DBL  = {TAPS, TAPS} << i;
        localparam logic [W-1:0]   MASK = DBL[2*W-1:W];
        assign y_o[i] = (^(a_i & MASK)) ^ CONST[i];
    end
endmodule

// File: rtl/gf_euclid_step.sv
module gf_euclid_step
    import sbsub_pkg::*;
(
    input  logic [POLY_W-1:0] u_i,
    input  logic [POLY_W-1:0] v_i,
    input  logic [POLY_W-1:0] g1_i,
    input  logic [POLY_W-1:0] g2_i,
    output logic [POLY_W-1:0] u_o,
    output logic [POLY_W-1:0] v_o,
    output logic [POLY_W-1:0] g1_o,
    output logic [POLY_W-1:0] g2_o,
    output logic              fin_o,
    output logic [BYTE_W-1:0] inv_o
);
    logic [DEG_W-1:0] du, dv, sh;
    logic             u_ge;

    assign du   = poly_deg(u_i);
    assign dv   = poly_deg(v_i);
    assign u_ge = (du >= dv);
    assign sh   = u_ge ? (du - dv) : (dv - du);

    always_comb begin
        u_o   = u_i;
        v_o   = v_i;
        g1_o  = g1_i;
        g2_o  = g2_i;
        fin_o = 1'b0;
        inv_o = '0;
        if (u_i == '0) begin
            fin_o = 1'b1;
        end else if (u_i == POLY_W'(1)) begin
            fin_o = 1'b1;
            inv_o = g1_i[BYTE_W-1:0];
        end else if (v_i == POLY_W'(1)) begin
            fin_o = 1'b1;
            inv_o = g2_i[BYTE_W-1:0];
        end else if (u_ge) begin
            u_o  = u_i ^ (v_i << sh);
            g1_o = g1_i ^ (g2_i << sh);
        end else begin
            v_o  = v_i ^ (u_i << sh);
            g2_o = g2_i ^ (g1_i << sh);
        end
    end
endmodule

// File: rtl/byte_sub_unit.sv
module byte_sub_unit
    import sbsub_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       decrypt,
    input  logic [7:0] din,
    output logic       busy,
    output logic       done,
    output logic [7:0] dout
);
    sbsub_regs_t regs_d, regs_q;

    logic [BYTE_W-1:0] pre_inv, post_fwd, step_inv;
    logic [POLY_W-1:0] su, sv, sg1, sg2;
    logic              step_fin;

    // reverse direction: inverse affine before the inverter
    gf_affine #(.W(BYTE_W), .TAPS(8'hA4), .CONST(8'h05)) u_pre (
        .a_i (din),
        .y_o (pre_inv)
    );

    // forward direction: affine after the inverter
    gf_affine #(.W(BYTE_W), .TAPS(8'hF1), .CONST(8'h63)) u_post (
        .a_i (regs_q.inv),
        .y_o (post_fwd)
    );

    gf_euclid_step u_step (
        .u_i   (regs_q.u),
        .v_i   (regs_q.v),
        .g1_i  (regs_q.g1),
        .g2_i  (regs_q.g2),
        .u_o   (su),
        .v_o   (sv),
        .g1_o  (sg1),
        .g2_o  (sg2),
        .fin_o (step_fin),
        .inv_o (step_inv)
    );

    always_comb begin
        regs_d = regs_q;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start) begin
                    regs_d.st   = ST_ITER;
                    regs_d.mode = decrypt;
                    regs_d.u    = {1'b0, (decrypt ? pre_inv : din)};
                    regs_d.v    = FIELD_POLY;
                    regs_d.g1   = POLY_W'(1);
                    regs_d.g2   = '0;
                end
            end
            ST_ITER: begin
                if (step_fin) begin
                    regs_d.inv = step_inv;
                    regs_d.st  = ST_AFF;
                end else begin
                    regs_d.u  = su;
                    regs_d.v  = sv;
                    regs_d.g1 = sg1;
                    regs_d.g2 = sg2;
                end
            end
            ST_AFF: begin
                regs_d.res = regs_q.mode ? regs_q.inv : post_fwd;
                regs_d.st  = ST_DONE;
            end
            ST_DONE: begin
                regs_d.st = ST_IDLE;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, mode: 1'b0, u: '0, v: '0,
                        g1: '0, g2: '0, inv: '0, res: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign busy = (regs_q.st != ST_IDLE);
    assign done = (regs_q.st == ST_DONE);
    assign dout = regs_q.res;
endmodule

// File: rtl/sbsub_chk.sv
module sbsub_chk #(
    parameter int LAT_MAX = 18
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [7:0] dout
);
    localparam int CW = $clog2(LAT_MAX + 2);
    logic [CW-1:0] busy_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          busy_cnt_q <= '0;
        else if (!busy)      busy_cnt_q <= '0;
        else                 busy_cnt_q <= busy_cnt_q + 1'b1;
    end

    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_dout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!done) |-> $stable(dout));

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_done_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    p_after_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_cnt_q < CW'(LAT_MAX)));
endmodule

bind byte_sub_unit sbsub_chk #(.LAT_MAX(18)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy),
    .done  (done),
    .dout  (dout)
);

// File: tb/sim_byte_sub_unit.sv
module sim_byte_sub_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       decrypt = 1'b0;
    logic [7:0] din = 8'h00;
    logic       busy, done;
    logic [7:0] dout;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] ref_fwd [256];
    logic [7:0] ref_rev [256];

    always #4 clk = ~clk;

    byte_sub_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .decrypt(decrypt),
        .din(din), .busy(busy), .done(done), .dout(dout)
    );

    function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p = 8'h00;
        logic [7:0] x = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p = p ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1B) : (x << 1);
        end
        return p;
    endfunction

    function automatic logic [7:0] rotl(input logic [7:0] a, input int k);
        logic [15:0] d = {a, a} << k;
        return d[15:8];
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic md, input logic [7:0] x,
                          output logic [7:0] y, output int lat);
        @(negedge clk);
        din = x; decrypt = md; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        y = dout;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] y, y2, held;
        int lat;
        bit ok;

        // reference tables: inverse by search, affine as rotation sum
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b = 8'h00;
            for (int c = 1; c < 256; c++)
                if (a != 0 && gmul(8'(a), 8'(c)) == 8'h01) b = 8'(c);
            ref_fwd[a] = b ^ rotl(b,1) ^ rotl(b,2) ^ rotl(b,3) ^ rotl(b,4) ^ 8'h63;
        end
        for (int a = 0; a < 256; a++) ref_rev[ref_fwd[a]] = 8'(a);

        // R1: reset state
        repeat (3) @(negedge clk);
        check(!done && !busy && dout == 8'h00, "R1 reset", {done, busy, dout}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !busy && dout == 8'h00, "R1 after release", {done, busy, dout}, 0);

        // R2 / R8 / R6: forward sweep
        ok = 1'b1;
        for (int a = 0; a < 256; a++) begin
            run_op(1'b0, 8'(a), y, lat);
            check(y == ref_fwd[a], "R2 forward", y, ref_fwd[a]);
            check(lat <= 18, "R8 latency", lat, 18);
            @(negedge clk);
            check(!done && !busy, "R6 single done", {done, busy}, 0);
        end

        // R4: reverse sweep
        for (int a = 0; a < 256; a++) begin
            run_op(1'b1, 8'(a), y, lat);
            check(y == ref_rev[a], "R4 reverse", y, ref_rev[a]);
            check(lat <= 18, "R8 latency", lat, 18);
        end

        // R5: round trip through the unit itself
        for (int a = 0; a < 256; a++) begin
            run_op(1'b0, 8'(a), y, lat);
            run_op(1'b1, y, y2, lat);
            check(y2 == 8'(a), "R5 round trip", y2, a);
        end

        // R3 / R9: zero handling and known values
        run_op(1'b0, 8'h00, y, lat);
        check(y == 8'h63, "R3 R9 zero forward", y, 8'h63);
        run_op(1'b1, 8'h63, y, lat);
        check(y == 8'h00, "R3 zero reverse", y, 8'h00);
        run_op(1'b0, 8'h53, y, lat);
        check(y == 8'hED, "R9 0x53", y, 8'hED);

        // R6: output held while idle
        held = dout;
        repeat (5) @(negedge clk);
        check(dout == held && !done, "R6 hold", dout, held);

        // R7: start while busy is ignored
        @(negedge clk);
        din = 8'h53; decrypt = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy, "R8 busy rises", busy, 1);
        @(negedge clk);
        din = 8'h00; decrypt = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        check(dout == 8'hED, "R7 ignored start", dout, 8'hED);
        @(negedge clk);
        check(!busy && !done, "R7 no second job", {busy, done}, 0);
        repeat (20) @(negedge clk);
        check(!done && dout == 8'hED, "R7 no extra done", dout, 8'hED);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule